// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block interprets the bus write cycles that software issues to a parallel NOR flash using a two-cycle command protocol. Each write is decoded by what came before it. In the idle cycle the low data byte is a command opcode. In later cycles the write is an argument: the byte to store, an erase confirm, a lock argument, a word count or a buffered data word. The block keeps the latched command, the current cycle of the sequence and a 16-bit buffered-write counter.

It updates an 8-bit status register. It also drives a read-mode output, which tells the surrounding read path whether a bus read returns array data, the status byte, identifier data or query data. Program and erase operate on a small internal byte array whose sector size is a parameter. A write-protect input blocks array changes and reports the blocked operation through the status register instead.

The array content is visible through a separate combinational read port, so the system read path can select it whenever the read-mode output says array.

Top module: `pflash_cmd_seq`

## Requirements
- R1: A synchronous active-low reset clears the status register to 0x00, clears the latched command and the cycle state, and sets the read mode to array (`rd_mode` = 0). The array comes out of reset fully erased, with every byte 0xFF.
- R2: In the idle cycle only the low data byte is decoded as an opcode. The upper bits of the bus word are ignored. Read-mode encoding: 0 = array, 1 = status, 2 = identifier, 3 = query. Opcode 0x70 gives mode 1 and 0x90 gives mode 2. The opcodes 0xFF, 0xF0 and 0x00, and any opcode the block does not recognise, return the device to mode 0.
- R3: Opcode 0x10 or 0x40 starts a program. The next write stores its low data byte at the bus address and sets status bit 7 (ready).
- R4: Opcode 0x20 starts a block erase. If the next write carries 0xD0, every byte of the sector that holds that write's address becomes 0xFF and status bit 7 is set. The sector is found by aligning the address down to the sector size. A second write of 0xFF, or of any other value, erases nothing and returns to mode 0.
- R5: While `wp` is high, a program completion leaves the array unchanged and sets status bit 4, and an erase confirm leaves the array unchanged and sets status bit 5. Bit 7 is set in both cases.
- R6: Opcode 0xE8 sets status bit 7 and starts a buffered write. The next word is a count, masked to the device width (the low byte by default). The next count+1 words are each stored as data at their own address. The write after them must be 0xD0, which returns to idle with the mode still 1. Any other value there returns to mode 0.
- R7: Opcode 0x60 starts lock/unlock. A second write of 0xD0 or 0x01 sets bit 7 and returns to idle, and the mode stays 1. Any other value returns to mode 0.
- R8: While the latched command is program, erase, lock, read-status or buffered write, the read mode is 1 (status). This includes the period after the operation has completed.
- R9: Opcode 0x50 sets the status register to 0x00 and returns to mode 0.
- R10: Opcode 0x98 enters query mode (mode 3). In that mode a write of 0xFF leaves to mode 0, and any other write keeps mode 3.
- R11: After a program or lock completes, the next write is decoded as a new opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Byte address of the bus write |
| wr_data | input | BUS_W | Bus write data; the low byte carries opcodes |
| wp | input | 1 | Write protect |
| rd_addr | input | ADDR_W | Address for array read-back |
| rd_data | output | 8 | Array byte at `rd_addr` |
| status | output | 8 | Status register (bit 7 ready, bit 5 erase error, bit 4 program error) |
| rd_mode | output | 2 | Read source: 0 array, 1 status, 2 identifier, 3 query |

## Verification
Two functions can land on the same clock edge. A completing write can change the array and set a status bit together, and with write protect high it must set the error bit while it does not change the array. The bench provokes this by confirming an erase and completing a program with `wp` high. After that edge it compares both the status byte and the array byte read back at the target address. The last buffered data word and the move into the confirm state also share an edge. A count whose upper byte is non-zero then shows whether the count was masked: without the mask, the confirm byte would be written into the array.

// File: rtl/pflash_pkg.sv
// Package: shared opcodes, read modes and sequence phases of the flash command sequencer.
// Assumes: opcodes are carried in the low byte of each bus write.
package pflash_pkg;

    typedef enum logic [1:0] {
        RD_ARRAY  = 2'd0,
        RD_STATUS = 2'd1,
        RD_IDENT  = 2'd2,
        RD_QUERY  = 2'd3
    } rd_mode_e;

    typedef enum logic [1:0] {
        PH_CMD     = 2'd0,
        PH_ARG     = 2'd1,
        PH_DATA    = 2'd2,
        PH_CONFIRM = 2'd3
    } phase_e;

    localparam logic [7:0] OP_NONE    = 8'h00;
    localparam logic [7:0] OP_PROG_A  = 8'h10;
    localparam logic [7:0] OP_PROG_B  = 8'h40;
    localparam logic [7:0] OP_ERASE   = 8'h20;
    localparam logic [7:0] OP_CLRST   = 8'h50;
    localparam logic [7:0] OP_LOCK    = 8'h60;
    localparam logic [7:0] OP_RDST    = 8'h70;
    localparam logic [7:0] OP_IDENT   = 8'h90;
    localparam logic [7:0] OP_QUERY   = 8'h98;
    localparam logic [7:0] OP_BUFWR   = 8'hE8;
    localparam logic [7:0] OP_CONFIRM = 8'hD0;
    localparam logic [7:0] OP_UNLOCK  = 8'h01;
    localparam logic [7:0] OP_ARRAY   = 8'hFF;

    localparam int ST_READY = 7;
    localparam int ST_ERERR = 5;
    localparam int ST_PGERR = 4;

endpackage

// File: rtl/pflash_seq.sv
// Module: command sequencer. Tracks the latched opcode, the phase of the
// sequence and the buffered-write counter, and issues one-cycle action strobes.
// Assumes: at most one bus write per cycle; the opcode is wr_data[7:0].
module pflash_seq
    import pflash_pkg::*;
#(
    parameter int BUS_W     = 16,
    parameter int DEV_BYTES = 1,
    parameter int CNT_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BUS_W-1:0] wr_data,
    output logic             prog_stb,
    output logic             erase_stb,
    output logic             ready_stb,
    output logic             clr_stb,
    output rd_mode_e         rd_mode
);

    localparam logic [BUS_W-1:0] CNT_MASK = {BUS_W{1'b1}} >> (BUS_W - 8 * DEV_BYTES);

    logic [7:0]       cmd_q, cmd_n;
    phase_e           ph_q, ph_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [7:0]       op;

    assign op = wr_data[7:0];

    // Next-state decode of one bus write against the latched command and phase.
    always_comb begin
        cmd_n     = cmd_q;
        ph_n      = ph_q;
        cnt_n     = cnt_q;
        prog_stb  = 1'b0;
        erase_stb = 1'b0;
        ready_stb = 1'b0;
        clr_stb   = 1'b0;
        if (wr_en) begin
            unique case (ph_q)
                PH_CMD: begin
                    unique case (op)
                        OP_PROG_A, OP_PROG_B, OP_ERASE, OP_LOCK, OP_QUERY: begin
                            cmd_n = op;
                            ph_n  = PH_ARG;
                        end
                        OP_BUFWR: begin
                            cmd_n     = op;
                            ph_n      = PH_ARG;
                            ready_stb = 1'b1;
                        end
                        OP_RDST, OP_IDENT: cmd_n = op;
                        OP_CLRST: begin
                            clr_stb = 1'b1;
                            cmd_n   = OP_NONE;
                        end
                        default: cmd_n = OP_NONE;
                    endcase
                end
                PH_ARG: begin
                    unique case (cmd_q)
                        OP_PROG_A, OP_PROG_B: begin
                            prog_stb = 1'b1;
                            ph_n     = PH_CMD;
                        end
                        OP_ERASE: begin
                            ph_n = PH_CMD;
                            if (op == OP_CONFIRM) erase_stb = 1'b1;
                            else                  cmd_n     = OP_NONE;
                        end
                        OP_LOCK: begin
                            ph_n = PH_CMD;
                            if (op == OP_CONFIRM || op == OP_UNLOCK) ready_stb = 1'b1;
                            else                                     cmd_n     = OP_NONE;
                        end
                        OP_BUFWR: begin
                            cnt_n = CNT_W'(wr_data & CNT_MASK);
                            ph_n  = PH_DATA;
                        end
                        OP_QUERY: begin
                            if (op == OP_ARRAY) begin
                                cmd_n = OP_NONE;
                                ph_n  = PH_CMD;
                            end
                        end
                        default: begin
                            cmd_n = OP_NONE;
                            ph_n  = PH_CMD;
                        end
                    endcase
                end
                PH_DATA: begin
                    prog_stb = 1'b1;
                    cnt_n    = cnt_q - 1'b1;
                    if (cnt_q == '0) ph_n = PH_CONFIRM;
                end
                PH_CONFIRM: begin
                    ph_n = PH_CMD;
                    if (op == OP_CONFIRM) ready_stb = 1'b1;
                    else                  cmd_n     = OP_NONE;
                end
                default: begin
                    cmd_n = OP_NONE;
                    ph_n  = PH_CMD;
                end
            endcase
        end
    end

    // Sequencer registers with synchronous reset to read-array idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= OP_NONE;
            ph_q  <= PH_CMD;
            cnt_q <= '0;
        end else begin
            cmd_q <= cmd_n;
            ph_q  <= ph_n;
            cnt_q <= cnt_n;
        end
    end

    // Read-source selection from the latched command.
    always_comb begin
        unique case (cmd_q)
            OP_PROG_A, OP_PROG_B, OP_ERASE, OP_LOCK, OP_RDST, OP_BUFWR: rd_mode = RD_STATUS;
            OP_IDENT: rd_mode = RD_IDENT;
            OP_QUERY: rd_mode = RD_QUERY;
            default:  rd_mode = RD_ARRAY;
        endcase
    end

    AST_CONFIRM_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_CONFIRM && $past(ph_q) != PH_CONFIRM) |-> ($past(ph_q) == PH_DATA && $past(cnt_q) == '0)); // R6
    AST_PROG_TO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        prog_stb |=> rd_mode == RD_STATUS); // R8
    AST_CLR_TO_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> rd_mode == RD_ARRAY); // R9

endmodule

// File: rtl/pflash_status.sv
// Module: status register. Collects ready and error flags from sequencer strobes.
// Assumes: the strobes last one cycle; a clear strobe wins over any set.
module pflash_status
    import pflash_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wp,
    input  logic       prog_stb,
    input  logic       erase_stb,
    input  logic       ready_stb,
    input  logic       clr_stb,
    output logic [7:0] status
);

    // Sticky flag accumulation with clear-by-command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= 8'h00;
        end else if (clr_stb) begin
            status <= 8'h00;
        end else begin
            if (prog_stb || erase_stb || ready_stb) status[ST_READY] <= 1'b1;
            if (prog_stb && wp)                     status[ST_PGERR] <= 1'b1;
            if (erase_stb && wp)                    status[ST_ERERR] <= 1'b1;
        end
    end

    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> status == 8'h00); // R1
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> status == 8'h00); // R9
    AST_READY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_stb || erase_stb) |=> status[ST_READY]); // R3
    AST_WP_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_stb && wp) |=> status[ST_PGERR]); // R5
    AST_WP_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_stb && wp) |=> status[ST_ERERR]); // R5

endmodule

// File: rtl/pflash_array.sv
// Module: byte array with single-byte write and whole-sector erase to 0xFF.
// Assumes: sector size is a power of two; array powers up erased.
module pflash_array #(
    parameter int ADDR_W = 6,
    parameter int SEC_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp,
    input  logic              prog_en,
    input  logic              erase_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int SIDX  = ADDR_W - SEC_W;

    logic [7:0]        mem_q [DEPTH];
    logic [ADDR_W-1:0] sec_base;

    assign sec_base = {addr[ADDR_W-1:SEC_W], {SEC_W{1'b0}}};

    for (genvar g = 0; g < DEPTH; g++) begin : g_byte
        // One byte cell: sector erase has priority over a byte write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[g] <= 8'hFF;
            end else if (erase_en && !wp && addr[ADDR_W-1:SEC_W] == SIDX'(g >> SEC_W)) begin
                mem_q[g] <= 8'hFF;
            end else if (prog_en && !wp && addr == ADDR_W'(g)) begin
                mem_q[g] <= data;
            end
        end
    end

    assign rd_data = mem_q[rd_addr];

    AST_ERASE_SECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_en && !wp) |=> mem_q[$past(sec_base)] == 8'hFF); // R4
    AST_WRITE_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en && !wp && !erase_en) |=> mem_q[$past(addr)] == $past(data)); // R3
    AST_WP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wp && (prog_en || erase_en)) |=> mem_q[$past(addr)] == $past(mem_q[addr])); // R5

endmodule

// File: rtl/pflash_cmd_seq.sv
// Module: top of the flash command sequencer. Joins the sequencer, status
// register and byte array. Assumes one write per cycle from the bus side.
module pflash_cmd_seq
    import pflash_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int SEC_W     = 4,
    parameter int BUS_W     = 16,
    parameter int DEV_BYTES = 1,
    parameter int CNT_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic              wp,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic [7:0]        status,
    output logic [1:0]        rd_mode
);

    logic     prog_stb, erase_stb, ready_stb, clr_stb;
    rd_mode_e mode_e;

    pflash_seq #(.BUS_W(BUS_W), .DEV_BYTES(DEV_BYTES), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .prog_stb(prog_stb), .erase_stb(erase_stb), .ready_stb(ready_stb),
        .clr_stb(clr_stb), .rd_mode(mode_e)
    );

    pflash_status u_status (
        .clk(clk), .rst_n(rst_n), .wp(wp), .prog_stb(prog_stb),
        .erase_stb(erase_stb), .ready_stb(ready_stb), .clr_stb(clr_stb),
        .status(status)
    );

    pflash_array #(.ADDR_W(ADDR_W), .SEC_W(SEC_W)) u_array (
        .clk(clk), .rst_n(rst_n), .wp(wp), .prog_en(prog_stb), .erase_en(erase_stb),
        .addr(wr_addr), .data(wr_data[7:0]), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    assign rd_mode = mode_e;

endmodule

// File: tb/pflash_cmd_seq_tb.sv
module pflash_cmd_seq_tb_top;

    localparam int NV = 37;
    localparam int VW = 55;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        wp = 1'b0;
    logic [5:0]  rd_addr = '0;
    logic [7:0]  rd_data, status;
    logic [1:0]  rd_mode;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    pflash_cmd_seq dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wp(wp), .rd_addr(rd_addr), .rd_data(rd_data), .status(status), .rd_mode(rd_mode)
    );

    // Row: req(4) data(16) addr(6) wp(1) mode(2) status(8) chk_addr(6) chk_byte(8) pad(4)
    localparam logic [VW-1:0] VEC [NV] = '{
        {4'd8,  16'h0040, 6'h00, 1'b0, 2'd1, 8'h00, 6'h05, 8'hFF, 4'h0}, // R8 program latched
        {4'd3,  16'h003C, 6'h05, 1'b0, 2'd1, 8'h80, 6'h05, 8'h3C, 4'h0}, // R3 byte stored
        {4'd11, 16'hAB70, 6'h00, 1'b0, 2'd1, 8'h80, 6'h05, 8'h3C, 4'h0}, // R11 R2 next write is opcode, upper byte ignored
        {4'd9,  16'h0050, 6'h00, 1'b0, 2'd0, 8'h00, 6'h05, 8'h3C, 4'h0}, // R9
        {4'd2,  16'h0090, 6'h00, 1'b0, 2'd2, 8'h00, 6'h05, 8'h3C, 4'h0}, // R2 identifier
        {4'd2,  16'h00FF, 6'h00, 1'b0, 2'd0, 8'h00, 6'h05, 8'h3C, 4'h0}, // R2
        {4'd10, 16'h0098, 6'h00, 1'b0, 2'd3, 8'h00, 6'h05, 8'h3C, 4'h0}, // R10
        {4'd10, 16'h0012, 6'h00, 1'b0, 2'd3, 8'h00, 6'h05, 8'h3C, 4'h0}, // R10 stays
        {4'd10, 16'h00FF, 6'h00, 1'b0, 2'd0, 8'h00, 6'h05, 8'h3C, 4'h0}, // R10 leaves
        {4'd3,  16'h0010, 6'h12, 1'b0, 2'd1, 8'h00, 6'h12, 8'hFF, 4'h0}, // R3
        {4'd3,  16'h00A5, 6'h12, 1'b0, 2'd1, 8'h80, 6'h12, 8'hA5, 4'h0}, // R3
        {4'd4,  16'h0020, 6'h13, 1'b0, 2'd1, 8'h80, 6'h12, 8'hA5, 4'h0}, // R4
        {4'd4,  16'h00FF, 6'h13, 1'b0, 2'd0, 8'h80, 6'h12, 8'hA5, 4'h0}, // R4 abort
        {4'd4,  16'h0020, 6'h17, 1'b0, 2'd1, 8'h80, 6'h12, 8'hA5, 4'h0}, // R4
        {4'd4,  16'h00D0, 6'h17, 1'b0, 2'd1, 8'h80, 6'h12, 8'hFF, 4'h0}, // R4 sector erased
        {4'd4,  16'h0050, 6'h00, 1'b0, 2'd0, 8'h00, 6'h05, 8'h3C, 4'h0}, // R4 other sector kept
        {4'd7,  16'h0060, 6'h00, 1'b0, 2'd1, 8'h00, 6'h05, 8'h3C, 4'h0}, // R7
        {4'd7,  16'h0001, 6'h00, 1'b0, 2'd1, 8'h80, 6'h05, 8'h3C, 4'h0}, // R7 unlock
        {4'd7,  16'h0060, 6'h00, 1'b0, 2'd1, 8'h80, 6'h05, 8'h3C, 4'h0}, // R7
        {4'd7,  16'h0033, 6'h00, 1'b0, 2'd0, 8'h80, 6'h05, 8'h3C, 4'h0}, // R7 bad arg
        {4'd2,  16'h00AB, 6'h00, 1'b0, 2'd0, 8'h80, 6'h05, 8'h3C, 4'h0}, // R2 unknown
        {4'd9,  16'h0050, 6'h00, 1'b0, 2'd0, 8'h00, 6'h05, 8'h3C, 4'h0}, // R9
        {4'd6,  16'h00E8, 6'h00, 1'b0, 2'd1, 8'h80, 6'h20, 8'hFF, 4'h0}, // R6 ready on start
        {4'd6,  16'h0302, 6'h00, 1'b0, 2'd1, 8'h80, 6'h20, 8'hFF, 4'h0}, // R6 count masked to 2
        {4'd6,  16'h0011, 6'h20, 1'b0, 2'd1, 8'h80, 6'h20, 8'h11, 4'h0}, // R6
        {4'd6,  16'h0022, 6'h21, 1'b0, 2'd1, 8'h80, 6'h21, 8'h22, 4'h0}, // R6
        {4'd6,  16'h0033, 6'h22, 1'b0, 2'd1, 8'h80, 6'h22, 8'h33, 4'h0}, // R6 last word
        {4'd6,  16'h00D0, 6'h23, 1'b0, 2'd1, 8'h80, 6'h23, 8'hFF, 4'h0}, // R6 confirm not stored
        {4'd6,  16'h00FF, 6'h00, 1'b0, 2'd0, 8'h80, 6'h20, 8'h11, 4'h0}, // R6 idle after confirm
        {4'd9,  16'h0050, 6'h00, 1'b0, 2'd0, 8'h00, 6'h30, 8'hFF, 4'h0}, // R9
        {4'd5,  16'h0040, 6'h30, 1'b0, 2'd1, 8'h00, 6'h30, 8'hFF, 4'h0}, // R5
        {4'd5,  16'h0077, 6'h30, 1'b1, 2'd1, 8'h90, 6'h30, 8'hFF, 4'h0}, // R5 program blocked
        {4'd9,  16'h0050, 6'h00, 1'b0, 2'd0, 8'h00, 6'h05, 8'h3C, 4'h0}, // R9
        {4'd5,  16'h0020, 6'h05, 1'b1, 2'd1, 8'h00, 6'h05, 8'h3C, 4'h0}, // R5
        {4'd5,  16'h00D0, 6'h05, 1'b1, 2'd1, 8'hA0, 6'h05, 8'h3C, 4'h0}, // R5 erase blocked
        {4'd4,  16'h0020, 6'h05, 1'b0, 2'd1, 8'hA0, 6'h05, 8'h3C, 4'h0}, // R4
        {4'd4,  16'h0044, 6'h05, 1'b0, 2'd0, 8'hA0, 6'h05, 8'h3C, 4'h0}  // R4 bad confirm
    };

    task automatic check(input int req, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] d, input logic [5:0] a, input logic p);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; wr_addr = a; wp = p;
        @(negedge clk);
        wr_en = 1'b0; wp = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(1, "status after reset", 16'(status), 16'h00);
        check(1, "mode after reset", 16'(rd_mode), 16'd0);
        rd_addr = 6'h3F;
        #1 check(1, "array erased after reset", 16'(rd_data), 16'hFF);

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            rd_addr = v[17:12];
            bus_write(v[50:35], v[34:29], v[28]);
            #1;
            check(int'(v[54:51]), $sformatf("row %0d mode", i), 16'(rd_mode), 16'(v[27:26]));
            check(int'(v[54:51]), $sformatf("row %0d status", i), 16'(status), 16'(v[25:18]));
            check(int'(v[54:51]), $sformatf("row %0d array", i), 16'(rd_data), 16'(v[11:4]));
        end

        // R2: 0xF0 leaves identifier mode
        bus_write(16'h0090, 6'h00, 1'b0);
        bus_write(16'h00F0, 6'h00, 1'b0);
        #1 check(2, "0xF0 to array", 16'(rd_mode), 16'd0);
        // R2: 0x00 in idle leaves status mode
        bus_write(16'h0070, 6'h00, 1'b0);
        bus_write(16'h0000, 6'h00, 1'b0);
        #1 check(2, "0x00 to array", 16'(rd_mode), 16'd0);
        // R1: reset in mid sequence with non-zero status
        bus_write(16'h0098, 6'h00, 1'b0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #1;
        check(1, "status after mid reset", 16'(status), 16'h00);
        check(1, "mode after mid reset", 16'(rd_mode), 16'd0);
        rd_addr = 6'h05;
        #1 check(1, "array re-erased after reset", 16'(rd_data), 16'hFF);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule